// File: doc/BRIEF.md
# Freezable Controlled Clock Generator

This block derives a set of controlled clocks and a controlled reset from a single free-running uncontrolled clock. Every controlled clock has its own period and high time, both counted in uncontrolled cycles and set by parameters. The transactor logic that surrounds a design under test runs on the uncontrolled clock and drives the design under test from the controlled clocks.

Each transactor has one stop-request input. While any request is raised, all controlled clocks freeze together at their present level. They resume from the same phase once every request is dropped. A broadcast status tells every transactor, including those that made no request, that controlled time is standing still. A per-clock strobe marks the uncontrolled cycle in which each controlled clock rises, so transactors know when a controlled edge is valid for sampling. The controlled reset stays asserted for a programmed number of controlled cycles of clock 0 and is released only as controlled time advances.

Top module: `cclk_gen`

## Requirements
- R1: While `urst_n` is low, every `cclk` bit is 0, every `cedge` bit is 0, every `ctime_stopped` bit is 0 and `crst_n` is 0.
- R2: Without stop requests, clock i repeats with a period of PERIOD_i uncontrolled cycles and is high for the first HIGH_i cycles of each period. Its first rising level appears in the first sampled cycle after `urst_n` is released.
- R3: When the OR of `stop_req` is 1 at an uncontrolled edge, no controlled clock changes level at the following edge. All clocks hold together for as long as the requests stay high.
- R4: `ctime_stopped` is 1, identically on every bit, in exactly those cycles whose clock levels were held rather than advanced. It is 1 regardless of which transactor requested the stop.
- R5: After the requests are released, the clocks continue from the phase at which they stopped. Counting only advancing cycles, each period still spans PERIOD_i cycles with HIGH_i high cycles, across any number of stops.
- R6: `cedge[i]` is a one-cycle pulse that is 1 exactly in the cycle where `cclk[i]` changes from 0 to 1. It is never 1 in a cycle in which `ctime_stopped` is 1.
- R7: `crst_n` rises in the cycle after the RST_CYC-th pulse on `cedge[0]` and stays high until `urst_n` is asserted. Frozen cycles do not count toward the reset length.
- R8: A request from any single transactor (bit 0, 1 or 2 of `stop_req` with three transactors) has the same effect as a request from all of them.
- R9: Asserting `urst_n` low in the middle of operation returns all outputs to the R1 state. A later release restarts the sequence of R2 and R7 from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uclk | input | 1 | free-running uncontrolled clock |
| urst_n | input | 1 | asynchronous active-low reset, released synchronously |
| stop_req | input | NUM_XACT | one stop request per transactor |
| cclk | output | NUM_CLK | controlled clock levels |
| cedge | output | NUM_CLK | per-clock rising-edge strobes |
| ctime_stopped | output | NUM_XACT | per-transactor controlled-time-stopped status |
| crst_n | output | 1 | active-low controlled reset |

## Verification
The bench builds the block with three transactors and two controlled clocks. Clock 0 has a period of 4 with a high time of 2, and clock 1 has a period of 6 with a high time of 2. The controlled reset lasts 3 cycles. The two periods are short and not multiples of each other, so every request pattern lands on a different mix of phases within a few dozen cycles, including stops that begin on a rising edge or during a low phase. A reset length of 3 lets a freeze cover the controlled-reset window, which shows that frozen cycles are excluded from the count.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  // width of one per-clock field in the period and high-time parameter vectors
  localparam int unsigned FW = 8;
  typedef logic [FW-1:0] cyc_t;
endpackage

// File: rtl/cclk_stop_merge.sv
module cclk_stop_merge #(
  parameter int unsigned NUM_XACT = 3
) (
  input  logic                uclk,
  input  logic                urst_n,
  input  logic [NUM_XACT-1:0] stop_req,
  output logic                adv,
  output logic                held
);
  logic stop_q, stop_d;
  logic held_q, held_d;

  always_comb begin
    stop_d = |stop_req;
    held_d = stop_q;
  end

  always_ff @(posedge uclk or negedge urst_n) begin
    if (!urst_n) begin
      stop_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      stop_q <= stop_d;
      held_q <= held_d;
    end
  end

  assign adv  = !stop_q;
  assign held = held_q;

  // R8: any single request bit stops advancing from the next edge
  p_any_req_freezes_r8: assert property (@(posedge uclk) disable iff (!urst_n)
    (|stop_req) |=> !adv);
  // R4: held reflects the advance decision of the previous edge
  p_held_follows_r4: assert property (@(posedge uclk) disable iff (!urst_n)
    !adv |=> held);
endmodule

// File: rtl/cclk_phase.sv
module cclk_phase #(
  parameter int unsigned PERIOD = 4,
  parameter int unsigned HIGH   = 2
) (
  input  logic uclk,
  input  logic urst_n,
  input  logic adv,
  output logic cclk,
  output logic edge_stb
);
  localparam int unsigned PW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);
  localparam logic [PW-1:0] HI   = PW'(HIGH);

  logic [PW-1:0] ph_q, ph_d;
  logic          clk_q, clk_d;
  logic          stb_q, stb_d;

  always_comb begin
    ph_d  = ph_q;
    clk_d = clk_q;
    stb_d = 1'b0;
    if (adv) begin
      ph_d  = (ph_q == LAST) ? '0 : ph_q + PW'(1);
      clk_d = (ph_d < HI);
      stb_d = (ph_d == '0);
    end
  end

  always_ff @(posedge uclk or negedge urst_n) begin
    if (!urst_n) begin
      ph_q  <= LAST;
      clk_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      clk_q <= clk_d;
      stb_q <= stb_d;
    end
  end

  assign cclk     = clk_q;
  assign edge_stb = stb_q;

  // R6: strobe coincides with a 0 -> 1 change of the clock level
  p_strobe_on_rise_r6: assert property (@(posedge uclk) disable iff (!urst_n)
    edge_stb |-> (cclk && !$past(cclk)));
  // R3: no advance means level held and no strobe
  p_hold_when_frozen_r3: assert property (@(posedge uclk) disable iff (!urst_n)
    !adv |=> ($stable(cclk) && !edge_stb));
endmodule

// File: rtl/cclk_rst_seq.sv
module cclk_rst_seq #(
  parameter int unsigned RST_CYC = 3
) (
  input  logic uclk,
  input  logic urst_n,
  input  logic stb0,
  output logic crst_n
);
  localparam int unsigned CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LASTC = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;

  always_comb begin
    cnt_d = cnt_q;
    rel_d = rel_q;
    if (stb0 && !rel_q) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == LASTC) rel_d = 1'b1;
    end
  end

  always_ff @(posedge uclk or negedge urst_n) begin
    if (!urst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assign crst_n = rel_q;

  // R7: release only right after a controlled edge of clock 0
  p_release_after_edge_r7: assert property (@(posedge uclk) disable iff (!urst_n)
    $rose(crst_n) |-> $past(stb0));
  // R7: once released, stays released
  p_release_sticky_r7: assert property (@(posedge uclk) disable iff (!urst_n)
    crst_n |=> crst_n);
endmodule

// File: rtl/cclk_gen.sv
module cclk_gen
  import cclk_pkg::*;
#(
  parameter int unsigned NUM_XACT = 3,
  parameter int unsigned NUM_CLK  = 2,
  parameter logic [NUM_CLK*FW-1:0] PERIOD_VEC = {8'd6, 8'd4},
  parameter logic [NUM_CLK*FW-1:0] HIGH_VEC   = {8'd2, 8'd2},
  parameter int unsigned RST_CYC  = 3
) (
  input  logic                uclk,
  input  logic                urst_n,
  input  logic [NUM_XACT-1:0] stop_req,
  output logic [NUM_CLK-1:0]  cclk,
  output logic [NUM_CLK-1:0]  cedge,
  output logic [NUM_XACT-1:0] ctime_stopped,
  output logic                crst_n
);
  logic adv;
  logic held;

  cclk_stop_merge #(.NUM_XACT(NUM_XACT)) u_merge (
    .uclk     (uclk),
    .urst_n   (urst_n),
    .stop_req (stop_req),
    .adv      (adv),
    .held     (held)
  );

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_clk
    localparam cyc_t PER_I = PERIOD_VEC[i*FW +: FW];
    localparam cyc_t HI_I  = HIGH_VEC[i*FW +: FW];
    cclk_phase #(.PERIOD(int'(PER_I)), .HIGH(int'(HI_I))) u_phase (
      .uclk     (uclk),
      .urst_n   (urst_n),
      .adv      (adv),
      .cclk     (cclk[i]),
      .edge_stb (cedge[i])
    );
    // R6: a clock may only rise together with its strobe
    p_rise_has_strobe_r6: assert property (@(posedge uclk) disable iff (!urst_n)
      (cclk[i] && !$past(cclk[i])) |-> cedge[i]);
  end

  for (genvar t = 0; t < NUM_XACT; t++) begin : g_stat
    assign ctime_stopped[t] = held;
  end

  cclk_rst_seq #(.RST_CYC(RST_CYC)) u_rst (
    .uclk   (uclk),
    .urst_n (urst_n),
    .stb0   (cedge[0]),
    .crst_n (crst_n)
  );

  // R6: no strobe while controlled time is stopped
  p_no_strobe_when_stopped_r6: assert property (@(posedge uclk) disable iff (!urst_n)
    ctime_stopped[0] |-> (cedge == '0));
  // R3: all clocks held together while stopped
  p_all_hold_r3: assert property (@(posedge uclk) disable iff (!urst_n)
    ctime_stopped[0] |-> $stable(cclk));
endmodule

// File: tb/cclk_gen_test.sv
module cclk_gen_test;
  localparam int NX = 3;
  localparam int NC = 2;
  localparam int PER [NC] = '{4, 6};
  localparam int HIG [NC] = '{2, 2};
  localparam int RSTC = 3;

  // stimulus table: [11:9] requests, [8:1] cycles to hold, [0] expected stopped at end
  localparam int NV = 11;
  localparam logic [11:0] STIM [NV] = '{
    {3'b000, 8'd12, 1'b0}, {3'b001, 8'd5, 1'b1}, {3'b000, 8'd7, 1'b0},
    {3'b010, 8'd3, 1'b1},  {3'b000, 8'd2, 1'b0}, {3'b100, 8'd9, 1'b1},
    {3'b000, 8'd5, 1'b0},  {3'b101, 8'd4, 1'b1}, {3'b000, 8'd10, 1'b0},
    {3'b111, 8'd2, 1'b1},  {3'b000, 8'd6, 1'b0}
  };

  logic uclk = 1'b0;
  logic urst_n;
  logic [NX-1:0] stop_req;
  logic [NC-1:0] cclk, cedge;
  logic [NX-1:0] ctime_stopped;
  logic crst_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // independent cycle model
  int m_ph [NC];
  bit m_clk [NC];
  bit m_edge [NC];
  bit m_stop, m_held, m_rel;
  int m_cnt;

  cclk_gen #(
    .NUM_XACT(NX), .NUM_CLK(NC),
    .PERIOD_VEC({8'd6, 8'd4}), .HIGH_VEC({8'd2, 8'd2}), .RST_CYC(RSTC)
  ) uut (
    .uclk(uclk), .urst_n(urst_n), .stop_req(stop_req),
    .cclk(cclk), .cedge(cedge), .ctime_stopped(ctime_stopped), .crst_n(crst_n)
  );

  always #4 uclk = ~uclk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit adv;
    if (!urst_n) begin
      for (int i = 0; i < NC; i++) begin
        m_ph[i] = PER[i] - 1; m_clk[i] = 0; m_edge[i] = 0;
      end
      m_stop = 0; m_held = 0; m_rel = 0; m_cnt = 0;
    end else begin
      adv = !m_stop;
      if (m_edge[0] && !m_rel) begin
        if (m_cnt == RSTC - 1) m_rel = 1;
        m_cnt++;
      end
      for (int i = 0; i < NC; i++) begin
        if (adv) begin
          m_ph[i] = (m_ph[i] == PER[i] - 1) ? 0 : m_ph[i] + 1;
          m_clk[i] = (m_ph[i] < HIG[i]);
          m_edge[i] = (m_ph[i] == 0);
        end else begin
          m_edge[i] = 0;
        end
      end
      m_held = m_stop;
      m_stop = |stop_req;
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < NC; i++) begin
      check(cclk[i] == m_clk[i], "R2 clock level", int'(cclk[i]), int'(m_clk[i]));
      check(cedge[i] == m_edge[i], "R6 edge strobe", int'(cedge[i]), int'(m_edge[i]));
    end
    check(ctime_stopped == {NX{m_held}}, "R4 stopped broadcast",
          int'(ctime_stopped), int'({NX{m_held}}));
    check(crst_n == m_rel, "R7 controlled reset", int'(crst_n), int'(m_rel));
  endtask

  // one uncontrolled cycle: edge, model update, compare at the falling edge
  task automatic tick();
    @(posedge uclk);
    model_step();
    @(negedge uclk);
    compare_all();
  endtask

  task automatic check_reset_state(input string tag);
    check(cclk == '0, tag, int'(cclk), 0);
    check(cedge == '0, tag, int'(cedge), 0);
    check(ctime_stopped == '0, tag, int'(ctime_stopped), 0);
    check(crst_n == 1'b0, tag, int'(crst_n), 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int adv_cnt, hi_cnt, nstb;
    bit first, prev_stb, seen_rel;
    urst_n = 1'b0;
    stop_req = '0;
    repeat (3) tick();
    check_reset_state("R1 reset state");
    @(negedge uclk);
    urst_n = 1'b1;

    // R7: freeze during the controlled-reset window, count strobes of clock 0
    nstb = 0; prev_stb = 0; seen_rel = 0;
    for (int c = 0; c < 40; c++) begin
      stop_req = (c % 5 < 2) ? 3'b010 : 3'b000;
      tick();
      if (crst_n && !seen_rel) begin
        seen_rel = 1;
        check(nstb == RSTC, "R7 reset length in controlled cycles", nstb, RSTC);
        check(prev_stb, "R7 release follows strobe", int'(prev_stb), 1);
      end
      if (!crst_n && cedge[0]) nstb++;
      prev_stb = cedge[0];
    end
    check(seen_rel, "R7 reset released", int'(seen_rel), 1);
    stop_req = '0;

    // table walk: R3, R4, R8
    for (int v = 0; v < NV; v++) begin
      stop_req = STIM[v][11:9];
      for (int c = 0; c < int'(STIM[v][8:1]); c++) tick();
      check(ctime_stopped == {NX{STIM[v][0]}}, "R8 request from any transactor",
            int'(ctime_stopped), int'({NX{STIM[v][0]}}));
    end

    // R3: levels hold across a long freeze
    stop_req = 3'b100;
    tick(); tick();
    begin
      logic [NC-1:0] snap;
      snap = cclk;
      repeat (7) tick();
      check(cclk == snap, "R3 clocks frozen together", int'(cclk), int'(snap));
      check(cedge == '0, "R6 no strobe while frozen", int'(cedge), 0);
    end
    stop_req = '0;

    // R5: period and duty preserved across irregular stops (clock 1)
    first = 1; adv_cnt = 0; hi_cnt = 0;
    for (int c = 0; c < 90; c++) begin
      stop_req = (c % 7 < 3) ? 3'b001 : 3'b000;
      tick();
      if (!ctime_stopped[1] && cedge[1]) begin
        if (!first) begin
          check(adv_cnt == PER[1], "R5 period across stops", adv_cnt, PER[1]);
          check(hi_cnt == HIG[1], "R5 high time across stops", hi_cnt, HIG[1]);
        end
        first = 0; adv_cnt = 1; hi_cnt = 1;
      end else if (!ctime_stopped[1]) begin
        adv_cnt++;
        if (cclk[1]) hi_cnt++;
      end
    end

    // R9: reset in mid run with a request active
    stop_req = 3'b011;
    tick();
    urst_n = 1'b0;
    #1;
    check_reset_state("R9 mid-run reset");
    tick(); tick();
    check_reset_state("R9 held in reset");
    urst_n = 1'b1;
    stop_req = '0;
    tick();
    check(cedge[0] && cedge[1], "R2 first rise after reset release", int'(cedge), 3);
    repeat (20) tick();
    check(crst_n == 1'b1, "R9 controlled reset sequence restarts", int'(crst_n), 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule